// File: doc/BRIEF.md
# Serial Flash Command Frame Checker

This block is the receive front end of a single-bit serial memory device. It samples the chip select, serial clock and serial data pins into the system clock domain and shifts one data bit in on every rising serial clock edge while chip select is low. The first complete byte of a frame is taken as the command opcode, and every later byte is handed on as a received byte. The opcode is sorted into one of three classes: commands that return data, commands that change device state, and opcodes with no defined meaning.

When chip select returns high, the block decides what happens to the frame. A data-returning command is always accepted, however many bits of its output phase went by. A state-changing command is accepted only if the number of serial clocks in the frame is an exact multiple of eight. Otherwise it is rejected, so a partly shifted program byte writes nothing and leaves the write-enable state as it was. An accepted frame gives a one-cycle execute pulse and a rejected frame gives a one-cycle reject pulse. An undefined opcode, or a frame too short to hold an opcode, gives neither pulse.

Top module: `sfc_top`

## Requirements
- R1: Bits are taken on rising `spi_sclk` edges while `spi_cs_n` is low, most significant bit first. Each completed group of eight bits appears on `rx_byte` together with a one-cycle `rx_valid` pulse.
- R2: The first byte of a frame is latched on `opcode`. Later bytes of the same frame leave `opcode` unchanged.
- R3: Opcodes 0x03, 0x0B, 0x05, 0xAB and 0x9F are data-returning. While such an opcode is the latched one, `cmd_read` is 1. For any other opcode it is 0.
- R4: State-changing opcodes are 0x02, 0x20, 0xD8, 0xC7, 0x01, 0x06, 0x04 and 0xB9. A frame with one of them whose total clock count is a nonzero multiple of eight ends with exactly one `exec_pulse`.
- R5: A frame with a state-changing opcode whose clock count is not a multiple of eight ends with exactly one `reject_pulse` and no `exec_pulse`.
- R6: A frame with a data-returning opcode ends with exactly one `exec_pulse`, whatever its clock count beyond the opcode byte.
- R7: A frame whose opcode is in neither list produces no `exec_pulse` and no `reject_pulse`.
- R8: A frame with fewer than eight clocks produces no `rx_valid`, no `exec_pulse` and no `reject_pulse`.
- R9: `exec_pulse` and `reject_pulse` are never high together. Each is high for one system clock cycle, and only after the rise of chip select has been synchronised.
- R10: Serial clock edges while chip select is high are ignored. Each frame starts counting bits from zero.
- R11: While `rst_n` is low, `opcode`, `rx_byte`, `rx_valid`, `cmd_read`, `exec_pulse` and `reject_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock pin, asynchronous |
| spi_cs_n | input | 1 | Active-low chip select pin, asynchronous |
| spi_si | input | 1 | Serial data input pin, asynchronous |
| opcode | output | 8 | First byte of the current or most recent frame |
| cmd_read | output | 1 | Latched opcode is data-returning |
| rx_byte | output | 8 | Most recently completed byte |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| exec_pulse | output | 1 | Frame accepted |
| reject_pulse | output | 1 | State-changing frame ended off a byte boundary |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a four-bit saturating byte counter. With these values a frame of up to 32 serial clocks runs through in a few hundred system cycles. That makes it affordable to send all 256 opcodes at a byte-aligned and a misaligned length, then sweep every defined opcode across every length from 9 to 32 clocks, and also run every sub-byte frame length. Stray serial clock pulses are sent with chip select high before part of the frames. The expected outcome of each frame is worked out from the opcode class and the clock count modulo eight.

// File: rtl/sfc_pkg.sv
// Shared types and opcode classification for the serial flash frame checker.
// Assumes single-bit transfers with an eight-bit command code.
package sfc_pkg;

    localparam int OP_W = 8;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_READ   = 2'd1,
        CLS_MODIFY = 2'd2
    } cmd_cls_t;

    // Map an opcode to its command class.
    function automatic cmd_cls_t classify(input logic [OP_W-1:0] op);
        cmd_cls_t c;
        unique case (op)
            8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F:               c = CLS_READ;
            8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h06,
            8'h04, 8'hB9:                                   c = CLS_MODIFY;
            default:                                        c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfc_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each pin stays stable for longer than one system clock period.
module sfc_sync #(
    parameter int             STAGES  = 2,
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/sfc_shifter.sv
// Bit counter and byte assembler for one chip-select frame.
// Assumes bit_stb never comes in two consecutive cycles. All frame state
// is cleared while the frame is inactive.
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_act,
    input  logic            bit_stb,
    input  logic            bit_in,
    output logic [OP_W-1:0] byte_data,
    output logic            byte_stb,
    output logic            byte_first,
    output logic            aligned,
    output logic            got_op
);

    localparam int IDX_W = $clog2(OP_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OP_W - 1);

    logic [IDX_W-1:0] idx;
    logic [OP_W-1:0]  shreg;
    logic [CNT_W-1:0] nbytes;
    logic [OP_W-1:0]  next_sh;

    assign next_sh = {shreg[OP_W-2:0], bit_in};

    // Count bits and bytes within the frame, cleared between frames.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_act) begin
            idx        <= '0;
            shreg      <= '0;
            nbytes     <= '0;
            byte_stb   <= 1'b0;
            byte_first <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (bit_stb) begin
                shreg <= next_sh;
                if (idx == IDX_LAST) begin
                    idx        <= '0;
                    byte_stb   <= 1'b1;
                    byte_first <= (nbytes == '0);
                    if (nbytes != '1) nbytes <= nbytes + 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Hold the last completed byte across frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_data <= '0;
        else if (frame_act && bit_stb && idx == IDX_LAST)
            byte_data <= next_sh;
    end

    assign aligned = (idx == '0);
    assign got_op  = (nbytes != '0);

    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);
    a_r1_strobe_from_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(bit_stb));
    a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> !byte_stb);

endmodule

// File: rtl/sfc_decider.sv
// Latches the opcode and its class. When the frame ends, decides whether
// the frame executes or is rejected. Assumes frame_end is a one-cycle pulse
// and that aligned and got_op still hold the frame's final values in that cycle.
module sfc_decider
    import sfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_end,
    input  logic            byte_stb,
    input  logic            byte_first,
    input  logic [OP_W-1:0] byte_data,
    input  logic            aligned,
    input  logic            got_op,
    output logic [OP_W-1:0] opcode,
    output logic            cmd_read,
    output logic            exec_pulse,
    output logic            reject_pulse
);

    cmd_cls_t cls_q;

    // Capture the opcode and its class from the first byte of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            cls_q  <= CLS_NONE;
        end else if (byte_stb && byte_first) begin
            opcode <= byte_data;
            cls_q  <= classify(byte_data);
        end
    end

    // Issue the one-cycle verdict when chip select has risen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_pulse   <= 1'b0;
            reject_pulse <= 1'b0;
        end else begin
            exec_pulse   <= 1'b0;
            reject_pulse <= 1'b0;
            if (frame_end && got_op) begin
                unique case (cls_q)
                    CLS_READ:   exec_pulse <= 1'b1;
                    CLS_MODIFY: begin
                        exec_pulse   <= aligned;
                        reject_pulse <= !aligned;
                    end
                    default:    ;
                endcase
            end
        end
    end

    assign cmd_read = (cls_q == CLS_READ);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_pulse && reject_pulse));
    a_r9_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |=> !exec_pulse);
    a_r9_reject_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |=> !reject_pulse);
    a_r9_after_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_pulse || reject_pulse) |-> $past(frame_end));
    a_r5_reject_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> !cmd_read);

endmodule

// File: rtl/sfc_top.sv
// Serial flash command frame checker, top level. Synchronises the pins,
// finds serial clock and chip select edges, and connects the assembler to
// the decider. Assumes the serial clock high and low phases each last at
// least two system clock periods.
module sfc_top
    import sfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_cs_n,
    input  logic            spi_si,
    output logic [OP_W-1:0] opcode,
    output logic            cmd_read,
    output logic [OP_W-1:0] rx_byte,
    output logic            rx_valid,
    output logic            exec_pulse,
    output logic            reject_pulse
);

    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

    logic [PIN_N-1:0] pins_sync;
    logic [1:0]       prev;
    logic             sclk_rise, cs_rise, frame_act;
    logic             byte_first, aligned, got_op;

    sfc_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_N), .RST_VAL(PIN_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({spi_si, spi_cs_n, spi_sclk}),
        .pin_sync (pins_sync)
    );

    // Remember the previous synchronised clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 2'b10;
        else        prev <= pins_sync[1:0];
    end

    assign sclk_rise = pins_sync[0] && !prev[0];
    assign cs_rise   = pins_sync[1] && !prev[1];
    assign frame_act = !pins_sync[1];

    sfc_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_act  (frame_act),
        .bit_stb    (sclk_rise && frame_act),
        .bit_in     (pins_sync[2]),
        .byte_data  (rx_byte),
        .byte_stb   (rx_valid),
        .byte_first (byte_first),
        .aligned    (aligned),
        .got_op     (got_op)
    );

    sfc_decider u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end    (cs_rise),
        .byte_stb     (rx_valid),
        .byte_first   (byte_first),
        .byte_data    (rx_byte),
        .aligned      (aligned),
        .got_op       (got_op),
        .opcode       (opcode),
        .cmd_read     (cmd_read),
        .exec_pulse   (exec_pulse),
        .reject_pulse (reject_pulse)
    );

    a_r8_no_verdict_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_pulse || reject_pulse) |-> $past(got_op));

endmodule

// File: tb/tb_sfc_top.sv
`timescale 1ns/1ps
module tb_sfc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_si = 1'b0;
    logic [7:0] opcode, rx_byte;
    logic       cmd_read, rx_valid, exec_pulse, reject_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int         m_exec, m_rej, m_rx;
    logic       m_read;
    logic [7:0] m_bytes [8];

    always #4 clk = ~clk;

    sfc_top dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .opcode(opcode), .cmd_read(cmd_read), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .exec_pulse(exec_pulse), .reject_pulse(reject_pulse)
    );

    // Monitor away from the active edge: count pulses and record bytes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exec_pulse) begin
                m_exec++;
                m_read = cmd_read;
            end
            if (reject_pulse) m_rej++;
            if (rx_valid) begin
                if (m_rx < 8) m_bytes[m_rx] = rx_byte;
                m_rx++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_cls(input logic [7:0] op);
        if (op inside {8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F}) return 1;
        if (op inside {8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h06, 8'h04, 8'hB9}) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] frame_byte(input logic [7:0] op, input int k);
        if (k == 0) return op;
        return op ^ (8'h5A + 8'(k));
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] op, input int nbits, input bit stray);
        int cls, ex_exec, ex_rej, nb;
        string tag;
        @(posedge clk);
        m_exec = 0; m_rej = 0; m_rx = 0; m_read = 1'b0;
        if (stray) begin
            spi_si = 1'b1;
            for (int s = 0; s < 3; s++) begin
                wait_clk(3); spi_sclk = 1'b1;
                wait_clk(3); spi_sclk = 1'b0;
            end
            wait_clk(3);
        end
        @(negedge clk); spi_cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            logic [7:0] b;
            b = frame_byte(op, i / 8);
            spi_si = b[7 - (i % 8)];
            wait_clk(3); spi_sclk = 1'b1;
            wait_clk(3); spi_sclk = 1'b0;
        end
        wait_clk(3); spi_cs_n = 1'b1;
        wait_clk(8);

        cls = ref_cls(op);
        nb  = nbits / 8;
        ex_exec = (nbits >= 8) && (cls == 1 || (cls == 2 && nbits % 8 == 0));
        ex_rej  = (nbits >= 8) && (cls == 2 && nbits % 8 != 0);
        if (nbits < 8)                          tag = "R8";
        else if (cls == 0)                      tag = "R7";
        else if (cls == 1)                      tag = "R6";
        else if (nbits % 8 == 0)                tag = "R4";
        else                                    tag = "R5";
        check(tag, "exec count", m_exec, ex_exec);
        check(tag, "reject count", m_rej, ex_rej);
        check("R1", "byte strobes", m_rx, nb);
        for (int k = 0; k < nb && k < 8; k++)
            check("R1", "byte value", int'(m_bytes[k]), int'(frame_byte(op, k)));
        if (nbits >= 8) begin
            check(stray ? "R10" : "R2", "opcode", int'(opcode), int'(op));
            check("R3", "cmd_read level", int'(cmd_read), int'(cls == 1));
        end
        if (ex_exec) check("R3", "cmd_read at exec", int'(m_read), int'(cls == 1));
        check("R9", "pulse cycles", m_exec + m_rej, ex_exec + ex_rej);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] defined [13] = '{8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F, 8'h02, 8'h20,
                                     8'hD8, 8'hC7, 8'h01, 8'h06, 8'h04, 8'hB9};
        wait_clk(5);
        check("R11", "opcode in reset", int'(opcode), 0);
        check("R11", "rx_byte in reset", int'(rx_byte), 0);
        check("R11", "rx_valid in reset", int'(rx_valid), 0);
        check("R11", "cmd_read in reset", int'(cmd_read), 0);
        check("R11", "exec in reset", int'(exec_pulse), 0);
        check("R11", "reject in reset", int'(reject_pulse), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_clk(5);

        for (int op = 0; op < 256; op++) begin
            run(8'(op), 8, 1'b0);
            run(8'(op), 13, 1'b0);
        end
        for (int d = 0; d < 13; d++)
            for (int len = 9; len <= 32; len++)
                run(defined[d], len, len % 3 == 0);
        for (int len = 0; len < 8; len++) begin
            run(8'h06, len, 1'b0);
            run(8'h03, len, 1'b1);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule